// File: doc/BRIEF.md
# Two-Stage Bit-Rate Divider

This block derives the bit timing of a serial port from a reference clock. Two counters are cascaded. The first divides its source by a 16-bit clock divisor and emits a one-cycle sample-enable pulse. The second counts those sample pulses and emits a one-cycle bit tick once every (bit-divisor + 1) samples.

The resulting bit rate is f_ref / (CD × (BD + 1)). When the source-select bit is set, f_ref is first divided by 8. The shifters and receive logic sit downstream and consume these two strobes.

Software programs the block through a simple write-strobe register port with a combinational read-back. Any write to either divisor restarts both counters from a known phase. A divisor of zero parks the sample strobe. The bit-divisor is held to a floor of 4 on write.

Top module: `bitrate_gen`

## Requirements
- R1: After reset both strobes are low, the clock divisor reads 0, the bit-divisor reads 15 and the source-select bit reads 0.
- R2: With source select 0 and clock divisor CD ≥ 1, sample_en_o pulses exactly once every CD clock cycles.
- R3: While the clock divisor is 0, neither sample_en_o nor baud_tick_o is ever asserted.
- R4: baud_tick_o is asserted only in a cycle where sample_en_o is also asserted. It fires on every (BD+1)-th sample pulse.
- R5: A bit-divisor write whose low 8 bits are below 4 stores 4. Write-data bits above bit 7 are dropped, so 0x1FF stores 0xFF.
- R6: With source select 1 (bit 0 of the mode register at offset 0x04), the clock divisor counts one step every 8 reference cycles, and the sample period becomes 8 × CD cycles.
- R7: A write to the clock divisor (offset 0x18) or to the bit-divisor (offset 0x34) restarts both counters. Neither strobe is high in the cycle after the write edge. The first sample pulse appears P cycles after that edge and the first bit tick P × (BD+1) cycles after it, where P is the sample period.
- R8: Registers read back at their offsets: the clock divisor in bits 15:0 at 0x18, the bit-divisor in bits 7:0 at 0x34 and source select in bit 0 at 0x04. Writes to any other offset change none of them.
- R9: With CD = 1 and source select 0, sample_en_o stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sample_en_o | output | 1 | One-cycle sample strobe |
| baud_tick_o | output | 1 | One-cycle bit strobe |

## Verification
The divider chain is run with a small divisor pair (3, 4), which separates an off-by-one in either stage. The pair (1, 4) exposes a stage that cannot pulse back to back. A large bit-divisor (255) with CD = 7 catches truncation in the second counter. A pre-divided source with CD = 2 shows whether the divide-by-8 path is applied once and with the right phase.

For each pattern the bench checks the following:
- the first-pulse latency after the reloading write;
- the pulse counts in a fixed window;
- that every bit tick coincides with a sample.

Together these distinguish a phase error from a rate error. The clamp, the dropped high bits and the ignored offsets are checked through read-back and through the resulting tick spacing.

// File: rtl/bitgen_pkg.sv
package bitgen_pkg;
  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_DIV8   = 1'b1
  } src_sel_e;
endpackage

// File: rtl/bitgen_regs.sv
module bitgen_regs
  import bitgen_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned CD_W      = 16,
  parameter int unsigned BD_W      = 8,
  parameter int unsigned BD_MIN    = 4,
  parameter int unsigned CD_ADDR   = 'h18,
  parameter int unsigned BD_ADDR   = 'h34,
  parameter int unsigned MODE_ADDR = 'h04,
  parameter int unsigned RST_CD    = 0,
  parameter int unsigned RST_BD    = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CD_W-1:0] cd_o,
  output logic [BD_W-1:0] bd_o,
  output src_sel_e        sel_o,
  output logic            reload_o
);
  localparam logic [BD_W-1:0] BD_FLOOR = BD_W'(BD_MIN);

  logic hit_cd, hit_bd, hit_mode;
  logic [BD_W-1:0] bd_raw, bd_next;

  assign hit_cd   = addr_i == AW'(CD_ADDR);
  assign hit_bd   = addr_i == AW'(BD_ADDR);
  assign hit_mode = addr_i == AW'(MODE_ADDR);
  assign reload_o = we_i && (hit_cd || hit_bd);

  assign bd_raw  = wdata_i[BD_W-1:0];
  assign bd_next = (bd_raw < BD_FLOOR) ? BD_FLOOR : bd_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_o  <= CD_W'(RST_CD);
      bd_o  <= BD_W'(RST_BD);
      sel_o <= SRC_DIRECT;
    end else if (we_i) begin
      if (hit_cd)   cd_o  <= wdata_i[CD_W-1:0];
      if (hit_bd)   bd_o  <= bd_next;
      if (hit_mode) sel_o <= src_sel_e'(wdata_i[0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cd)        rdata_o = DW'(cd_o);
    else if (hit_bd)   rdata_o = DW'(bd_o);
    else if (hit_mode) rdata_o = DW'(sel_o);
  end
endmodule

// File: rtl/bitgen_prescale.sv
module bitgen_prescale
  import bitgen_pkg::*;
#(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     reload_i,
  input  src_sel_e sel_i,
  output logic     src_en_o
);
  generate
    if (PRE_DIV <= 1) begin : g_bypass
      assign src_en_o = 1'b1;
    end else begin : g_count
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (reload_i || sel_i == SRC_DIRECT) cnt_q <= '0;
        else if (cnt_q == LAST)            cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end

      assign src_en_o = (sel_i == SRC_DIRECT) || (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/bitgen_div.sv
module bitgen_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reload_i,
  input  logic         enable_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic at_last;

  assign at_last = cnt_q == last_i;
  assign hit_o   = enable_i && step_i && at_last && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (reload_i || !enable_i) cnt_q <= '0;
    else if (step_i)            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bitgen_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned CD_W      = 16,
  parameter int unsigned BD_W      = 8,
  parameter int unsigned BD_MIN    = 4,
  parameter int unsigned PRE_DIV   = 8,
  parameter int unsigned CD_ADDR   = 'h18,
  parameter int unsigned BD_ADDR   = 'h34,
  parameter int unsigned MODE_ADDR = 'h04,
  parameter int unsigned RST_CD    = 0,
  parameter int unsigned RST_BD    = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sample_en_o,
  output logic          baud_tick_o
);
  logic [CD_W-1:0] cd_q;
  logic [BD_W-1:0] bd_q;
  src_sel_e        sel_q;
  logic            reload;
  logic            src_en, cd_on, smp_hit, bit_hit;

  bitgen_regs #(
    .AW(AW), .DW(DW), .CD_W(CD_W), .BD_W(BD_W), .BD_MIN(BD_MIN),
    .CD_ADDR(CD_ADDR), .BD_ADDR(BD_ADDR), .MODE_ADDR(MODE_ADDR),
    .RST_CD(RST_CD), .RST_BD(RST_BD)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cd_o(cd_q), .bd_o(bd_q),
    .sel_o(sel_q), .reload_o(reload)
  );

  bitgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload),
    .sel_i(sel_q), .src_en_o(src_en)
  );

  assign cd_on = cd_q != '0;

  bitgen_div #(.W(CD_W)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload), .enable_i(cd_on),
    .step_i(src_en), .last_i(cd_q - 1'b1), .hit_o(smp_hit)
  );

  bitgen_div #(.W(BD_W)) u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload), .enable_i(1'b1),
    .step_i(smp_hit), .last_i(bd_q), .hit_o(bit_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_en_o <= 1'b0;
      baud_tick_o <= 1'b0;
    end else begin
      sample_en_o <= smp_hit;
      baud_tick_o <= bit_hit;
    end
  end
endmodule

module bitrate_gen_chk #(
  parameter int unsigned CD_W   = 16,
  parameter int unsigned BD_W   = 8,
  parameter int unsigned BD_MIN = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sample_en_o,
  input logic            baud_tick_o,
  input logic [CD_W-1:0] cd_q,
  input logic [BD_W-1:0] bd_q,
  input logic            reload
);
  p_bd_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bd_q >= BD_W'(BD_MIN));

  p_tick_on_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> sample_en_o);

  p_cd_zero_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_q == '0) |=> (!sample_en_o && !baud_tick_o));

  p_reload_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (!sample_en_o && !baud_tick_o));

  p_sample_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_o && cd_q > CD_W'(1) && !reload) |=> !sample_en_o);

  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_tick_o && !reload) |=> !baud_tick_o);
endmodule

bind bitrate_gen bitrate_gen_chk #(.CD_W(CD_W), .BD_W(BD_W), .BD_MIN(BD_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_en_o(sample_en_o),
  .baud_tick_o(baud_tick_o), .cd_q(cd_q), .bd_q(bd_q), .reload(reload)
);

// File: tb/sim_bitrate_gen.sv
module sim_bitrate_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CD = 8'h18, A_BD = 8'h34, A_MODE = 8'h04;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic sample_en_o, baud_tick_o;
  int n_chk = 0, n_fail = 0;

  bitrate_gen u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = int'(rdata_o);
  endtask

  // Called right after the reloading write; expected values from the requirements.
  task automatic observe(string req, int period, int bd, int n);
    int first_s = -1, first_t = -1, ns = 0, nt = 0, stray = 0;
    check("R7", {req, " strobes low after reload"}, int'(sample_en_o | baud_tick_o), 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk_i);
      if (sample_en_o) begin ns++; if (first_s < 0) first_s = k; end
      if (baud_tick_o) begin nt++; if (first_t < 0) first_t = k; end
      if (baud_tick_o && !sample_en_o) stray++;
    end
    check("R7", {req, " first sample"}, first_s, period);
    check("R7", {req, " first tick"}, first_t, (period*(bd+1) <= n) ? period*(bd+1) : -1);
    check("R2", {req, " sample count"}, ns, n / period);
    check("R4", {req, " tick count"}, nt, n / (period*(bd+1)));
    check("R4", {req, " tick without sample"}, stray, 0);
  endtask

  task automatic t_reset();
    int v;
    check("R1", "sample_en after reset", int'(sample_en_o), 0);
    check("R1", "baud_tick after reset", int'(baud_tick_o), 0);
    rd(A_CD, v);   check("R1", "cd reset", v, 0);
    rd(A_BD, v);   check("R1", "bd reset", v, 15);
    rd(A_MODE, v); check("R1", "mode reset", v, 0);
  endtask

  task automatic t_cd_zero();
    int cnt = 0;
    wr(A_BD, 4);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      if (sample_en_o || baud_tick_o) cnt++;
    end
    check("R3", "strobes with cd 0", cnt, 0);
  endtask

  task automatic t_direct();
    wr(A_MODE, 0); wr(A_CD, 3); wr(A_BD, 4);
    observe("R2 cd3 bd4", 3, 4, 40);
    wr(A_CD, 7); wr(A_BD, 255);
    observe("R4 cd7 bd255", 7, 255, 2000);
  endtask

  task automatic t_cd_one();
    int lows = 0;
    wr(A_MODE, 0); wr(A_BD, 4); wr(A_CD, 1);
    observe("R9 cd1 bd4", 1, 4, 20);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      if (!sample_en_o) lows++;
    end
    check("R9", "sample low cycles with cd 1", lows, 0);
  endtask

  task automatic t_prediv();
    wr(A_MODE, 1); wr(A_BD, 4); wr(A_CD, 2);
    observe("R6 div8 cd2 bd4", 16, 4, 170);
    wr(A_MODE, 0);
  endtask

  task automatic t_clamp();
    int v;
    wr(A_BD, 2);     rd(A_BD, v); check("R5", "bd write 2", v, 4);
    wr(A_BD, 0);     rd(A_BD, v); check("R5", "bd write 0", v, 4);
    wr(A_BD, 'h1FF); rd(A_BD, v); check("R5", "bd write 0x1FF", v, 255);
    wr(A_CD, 2); wr(A_BD, 1);
    observe("R5 clamped bd", 2, 4, 45);
  endtask

  task automatic t_reload();
    wr(A_MODE, 0); wr(A_BD, 4); wr(A_CD, 5);
    repeat (13) @(negedge clk_i);
    wr(A_CD, 5);
    observe("R7 cd rewrite", 5, 4, 60);
    repeat (7) @(negedge clk_i);
    wr(A_BD, 4);
    observe("R7 bd rewrite", 5, 4, 60);
  endtask

  task automatic t_decode();
    int v;
    wr(A_CD, 'h1234); wr(A_BD, 9); wr(A_MODE, 1);
    rd(A_CD, v);   check("R8", "cd readback", v, 'h1234);
    rd(A_BD, v);   check("R8", "bd readback", v, 9);
    rd(A_MODE, v); check("R8", "mode readback", v, 1);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h00, 32'h0);
    rd(A_CD, v);   check("R8", "cd after stray writes", v, 'h1234);
    rd(A_BD, v);   check("R8", "bd after stray writes", v, 9);
    rd(A_MODE, v); check("R8", "mode after stray writes", v, 1);
    rd(8'h20, v);  check("R8", "unmapped read", v, 0);
    wr(A_MODE, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cd_zero();
    t_direct();
    t_cd_one();
    t_prediv();
    t_clamp();
    t_reload();
    t_decode();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule